// File: doc/BRIEF.md
# NAND Flash Device Bus Front End

This block models the device side of an 8-bit NAND flash bus. It samples the chip select, command strobe, address strobe, write strobe, read strobe and write-protect pins on a system clock. A rising write strobe stores the bus byte as a command, an address or load data, depending on which latch strobe is high. A falling read strobe returns the next byte and advances the column pointer. A small memory stands behind the bus. Its page is 16 bytes, a block holds 4 pages, and there are 4 blocks. The memory powers up erased.

A countdown timer emulates the array delays of page read, page program and block erase. While it runs, the ready/busy output is low. A status byte can be read at any time, including while busy. Deselecting the chip stops a read, but it has no effect on a program or erase in progress. With write protect asserted, program and erase are refused and the fail flag is set instead.

Top module: `nand_fe`

## Requirements
- R1: After reset, rb_o is 1, io_oe_o is 0, every array byte reads FFh and the status byte is C0h.
- R2: A byte is taken on a rising we_ni only while ce_ni is 0. It is a command when cle_i=1, ale_i=0, an address when ale_i=1, cle_i=0, and data when both are 0. Writes with ce_ni=1 have no effect.
- R3: Page read is command 00h, then a column byte (low 4 bits), then a row byte (bits 3:2 block, bits 1:0 page). rb_o is then low for exactly T_READ cycles. Each later falling re_ni returns the byte at the column and increments the column, which wraps within the page.
- R4: Program is command 80h, column byte, row byte, any number of data bytes stored at successive columns with wrap, then command 10h. rb_o is then low for exactly T_PROG cycles. Each page byte becomes its old value ANDed with the loaded byte; bytes not loaded stay unchanged.
- R5: Erase is command 60h, one row byte, then D0h. rb_o is then low for exactly T_ERASE cycles. Every byte of the addressed block becomes FFh and other blocks are unchanged.
- R6: After command 70h, the status byte is {wp_ni, ready, 5'b0, fail} while re_ni is low. 70h is accepted while busy, and bit 6 equals rb_o at every sample.
- R7: With wp_ni=0, D0h and 10h do not start busy, leave the array unchanged and set status bit 0. Commands 60h and 80h clear that bit.
- R8: ce_ni=1 while idle or read-busy returns the block to idle, ends read busy and disables outputs. ce_ni=1 during program or erase busy is ignored and the operation completes.
- R9: io_oe_o is 1 only when ce_ni=0, re_ni=0 and status or read data has been selected.
- R10: A command code outside 00h, 10h, 60h, 70h, 80h and D0h changes nothing; a selected status output stays selected.
- R11: While busy, every command other than 70h is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock sampling all pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip select, active low |
| cle_i | input | 1 | Command latch strobe |
| ale_i | input | 1 | Address latch strobe |
| we_ni | input | 1 | Write strobe, byte taken on rising edge |
| re_ni | input | 1 | Read strobe, byte advanced on falling edge |
| wp_ni | input | 1 | Write protect, active low |
| io_i | input | 8 | Bus byte in |
| io_o | output | 8 | Bus byte out |
| io_oe_o | output | 1 | Output enable for io_o |
| rb_o | output | 1 | Ready (1) / busy (0) |

## Verification
Two events can land in the same clock edge: the busy timer finishing and a status read in progress. The bench provokes this by issuing 70h during an erase and then holding re_ni low through the end of the erase. At each sample it compares status bit 6 against rb_o, including on the cycle where rb_o rises. A second collision is a deselect that arrives while a program or erase is busy. The bench holds ce_ni high across part of an erase and checks that busy lasts its full length and that the block is erased afterwards.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ADDR, ST_RD_DATA, ST_ER_ADDR,
    ST_ER_CONF, ST_PG_ADDR, ST_PG_DATA, ST_BUSY
  } fe_state_e;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_PROG, OP_ERASE} fe_op_e;
  typedef enum logic [1:0] {OUT_NONE, OUT_STAT, OUT_DATA} fe_out_e;

  localparam logic [7:0] CMD_READ     = 8'h00;
  localparam logic [7:0] CMD_PROG_GO  = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h60;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_PROG     = 8'h80;
  localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
endpackage

// File: rtl/nand_bus_edge.sv
module nand_bus_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic re_ni,
  output logic wr_stb_o,
  output logic rd_stb_o
);
  logic we_q, re_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_ni;
      re_q <= re_ni;
    end
  end

  assign wr_stb_o = !we_q && we_ni && !ce_ni;
  assign rd_stb_o = re_q && !re_ni && !ce_ni;
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             clear_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clear_i)         cnt_q <= '0;
    else if (start_i)         cnt_q <= load_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1)) && !clear_i;
endmodule

// File: rtl/nand_array.sv
module nand_array #(
  parameter int COL_W = 4,
  parameter int PG_W  = 2,
  parameter int BLK_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [PG_W+BLK_W-1:0]  rd_row_i,
  input  logic [COL_W-1:0]       rd_col_i,
  output logic [7:0]             rd_data_o,
  input  logic                   buf_clr_i,
  input  logic                   buf_we_i,
  input  logic [COL_W-1:0]       buf_col_i,
  input  logic [7:0]             buf_data_i,
  input  logic                   prog_i,
  input  logic [PG_W+BLK_W-1:0]  prog_row_i,
  input  logic                   erase_i,
  input  logic [BLK_W-1:0]       erase_blk_i
);
  localparam int ROW_W     = PG_W + BLK_W;
  localparam int ADDR_W    = COL_W + ROW_W;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int PG_BYTES  = 1 << COL_W;
  localparam int BLK_BYTES = 1 << (COL_W + PG_W);

  logic [7:0] mem_q [DEPTH];
  logic [7:0] buf_q [PG_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PG_BYTES; i++) buf_q[i] <= 8'hFF;
    end else if (buf_clr_i) begin
      for (int i = 0; i < PG_BYTES; i++) buf_q[i] <= 8'hFF;
    end else if (buf_we_i) begin
      buf_q[buf_col_i] <= buf_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (erase_i) begin
      for (int i = 0; i < BLK_BYTES; i++)
        mem_q[{erase_blk_i, i[COL_W+PG_W-1:0]}] <= 8'hFF;
    end else if (prog_i) begin
      // program can only clear bits
      for (int j = 0; j < PG_BYTES; j++)
        mem_q[{prog_row_i, j[COL_W-1:0]}] <=
          mem_q[{prog_row_i, j[COL_W-1:0]}] & buf_q[j];
    end
  end

  assign rd_data_o = mem_q[{rd_row_i, rd_col_i}];
endmodule

// File: rtl/nand_fe.sv
module nand_fe
  import nand_fe_pkg::*;
#(
  parameter int COL_W   = 4,
  parameter int PG_W    = 2,
  parameter int BLK_W   = 2,
  parameter int T_READ  = 4,
  parameter int T_PROG  = 8,
  parameter int T_ERASE = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_ni,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_ni,
  input  logic       re_ni,
  input  logic       wp_ni,
  input  logic [7:0] io_i,
  output logic [7:0] io_o,
  output logic       io_oe_o,
  output logic       rb_o
);
  localparam int ROW_W = PG_W + BLK_W;
  localparam int CNT_W = $clog2(T_READ + T_PROG + T_ERASE + 1);

  fe_state_e        state_q;
  fe_op_e           op_q;
  fe_out_e          out_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic             acnt_q, fail_q;
  logic [7:0]       dout_q, rd_data, status;

  logic wr_stb, rd_stb, is_cmd, is_addr, is_data;
  logic busy, tmr_done, pe_busy, deselect, stat_sel;
  logic start_rd, start_pg, start_er, tmr_start;
  logic [CNT_W-1:0] tmr_load;

  nand_bus_edge i_edge (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .re_ni,
    .wr_stb_o(wr_stb), .rd_stb_o(rd_stb)
  );

  assign is_cmd  = wr_stb && cle_i && !ale_i;
  assign is_addr = wr_stb && ale_i && !cle_i;
  assign is_data = wr_stb && !cle_i && !ale_i;

  assign pe_busy  = busy && (op_q != OP_READ);
  assign deselect = ce_ni && !pe_busy;

  assign start_rd = is_addr && !busy && state_q == ST_RD_ADDR && acnt_q;
  assign start_pg = is_cmd && !busy && io_i == CMD_PROG_GO
                    && state_q == ST_PG_DATA && wp_ni;
  assign start_er = is_cmd && !busy && io_i == CMD_ERASE_GO
                    && state_q == ST_ER_CONF && wp_ni;
  assign tmr_start = start_rd || start_pg || start_er;

  always_comb begin
    tmr_load = CNT_W'(T_READ);
    if (start_pg) tmr_load = CNT_W'(T_PROG);
    if (start_er) tmr_load = CNT_W'(T_ERASE);
  end

  nand_busy_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i, .rst_ni,
    .start_i(tmr_start), .load_i(tmr_load),
    .clear_i(deselect && busy),
    .busy_o(busy), .done_o(tmr_done)
  );

  nand_array #(.COL_W(COL_W), .PG_W(PG_W), .BLK_W(BLK_W)) i_array (
    .clk_i, .rst_ni,
    .rd_row_i(row_q), .rd_col_i(col_q), .rd_data_o(rd_data),
    .buf_clr_i(is_cmd && !busy && io_i == CMD_PROG),
    .buf_we_i(is_data && !busy && state_q == ST_PG_DATA),
    .buf_col_i(col_q), .buf_data_i(io_i),
    .prog_i(tmr_done && op_q == OP_PROG), .prog_row_i(row_q),
    .erase_i(tmr_done && op_q == OP_ERASE),
    .erase_blk_i(row_q[ROW_W-1:PG_W])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      out_q   <= OUT_NONE;
      col_q   <= '0;
      row_q   <= '0;
      acnt_q  <= 1'b0;
      fail_q  <= 1'b0;
      dout_q  <= '0;
    end else if (deselect) begin
      state_q <= ST_IDLE;
      out_q   <= OUT_NONE;
      acnt_q  <= 1'b0;
    end else begin
      if (tmr_done) begin
        if (op_q == OP_READ) begin
          state_q <= ST_RD_DATA;
          out_q   <= OUT_DATA;
        end else begin
          state_q <= ST_IDLE;
        end
      end

      if (is_cmd) begin
        if (busy) begin
          if (io_i == CMD_STATUS) out_q <= OUT_STAT;
        end else begin
          unique case (io_i)
            CMD_READ: begin
              state_q <= ST_RD_ADDR;
              acnt_q  <= 1'b0;
              out_q   <= OUT_NONE;
            end
            CMD_ERASE: begin
              state_q <= ST_ER_ADDR;
              fail_q  <= 1'b0;
              out_q   <= OUT_NONE;
            end
            CMD_PROG: begin
              state_q <= ST_PG_ADDR;
              acnt_q  <= 1'b0;
              fail_q  <= 1'b0;
              out_q   <= OUT_NONE;
            end
            CMD_STATUS: out_q <= OUT_STAT;
            CMD_ERASE_GO: begin
              if (state_q == ST_ER_CONF) begin
                if (wp_ni) begin
                  op_q    <= OP_ERASE;
                  state_q <= ST_BUSY;
                end else begin
                  fail_q  <= 1'b1;
                  state_q <= ST_IDLE;
                end
              end
            end
            CMD_PROG_GO: begin
              if (state_q == ST_PG_DATA) begin
                if (wp_ni) begin
                  op_q    <= OP_PROG;
                  state_q <= ST_BUSY;
                end else begin
                  fail_q  <= 1'b1;
                  state_q <= ST_IDLE;
                end
              end
            end
            default: ;
          endcase
        end
      end

      if (is_addr && !busy) begin
        case (state_q)
          ST_RD_ADDR, ST_PG_ADDR: begin
            if (!acnt_q) begin
              col_q  <= io_i[COL_W-1:0];
              acnt_q <= 1'b1;
            end else begin
              row_q <= io_i[ROW_W-1:0];
              if (state_q == ST_RD_ADDR) begin
                op_q    <= OP_READ;
                state_q <= ST_BUSY;
              end else begin
                state_q <= ST_PG_DATA;
              end
            end
          end
          ST_ER_ADDR: begin
            row_q   <= io_i[ROW_W-1:0];
            state_q <= ST_ER_CONF;
          end
          default: ;
        endcase
      end

      if (is_data && !busy && state_q == ST_PG_DATA) col_q <= col_q + 1'b1;

      if (rd_stb && !busy && out_q == OUT_DATA) begin
        dout_q <= rd_data;
        col_q  <= col_q + 1'b1;
      end
    end
  end

  assign status   = {wp_ni, !busy, 5'b0, fail_q};
  assign stat_sel = (out_q == OUT_STAT);
  assign io_o     = stat_sel ? status : dout_q;
  assign io_oe_o  = !ce_ni && !re_ni && (out_q != OUT_NONE);
  assign rb_o     = !busy;
endmodule

// File: rtl/nand_fe_chk.sv
module nand_fe_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       we_ni,
  input logic       re_ni,
  input logic       wp_ni,
  input logic       ale_i,
  input logic       rb_o,
  input logic       io_oe_o,
  input logic [7:0] io_o,
  input logic       stat_sel,
  input logic       pe_busy,
  input logic       tmr_done
);
  AST_OE_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o |-> (!ce_ni && !re_ni)); // R9

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rb_o) |-> ($past(we_ni) && !$past(we_ni, 2) && !$past(ce_ni))); // R2

  AST_WP_BLOCKS_PE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rb_o) && !$past(wp_ni)) |-> $past(ale_i)); // R7

  AST_STATUS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_oe_o && stat_sel) |-> (io_o[6] == rb_o && io_o[7] == wp_ni)); // R6

  AST_PE_IGNORES_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rb_o) |-> ($past(tmr_done) || ($past(ce_ni) && !$past(pe_busy)))); // R8
endmodule

bind nand_fe nand_fe_chk i_nand_fe_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni),
  .re_ni(re_ni), .wp_ni(wp_ni), .ale_i(ale_i), .rb_o(rb_o),
  .io_oe_o(io_oe_o), .io_o(io_o), .stat_sel(stat_sel),
  .pe_busy(pe_busy), .tmr_done(tmr_done)
);

// File: tb/test_nand_fe.sv
module test_nand_fe;
  localparam int T_READ  = 4;
  localparam int T_PROG  = 8;
  localparam int T_ERASE = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = '0, io_out;
  logic oe, rb;

  int total = 0, bad = 0;
  logic [7:0] mdl [256];

  always #2 clk = ~clk;

  nand_fe #(.T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE)) i_nand_fe (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .cle_i(cle), .ale_i(ale),
    .we_ni(we_n), .re_ni(re_n), .wp_ni(wp_n), .io_i(io_in),
    .io_o(io_out), .io_oe_o(oe), .rb_o(rb)
  );

  // {row, col, count, seed}
  localparam logic [31:0] VEC [5] = '{
    32'h00_00_10_11, 32'h05_03_04_A0, 32'h06_0E_04_3C,
    32'h00_02_03_0F, 32'h0F_00_02_77
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk) cle = c; ale = a; io_in = d; we_n = 1'b0;
    @(negedge clk) we_n = 1'b1;
    @(negedge clk) cle = 1'b0; ale = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] d, output logic e);
    @(negedge clk) re_n = 1'b0;
    @(negedge clk) d = io_out; e = oe; re_n = 1'b1;
  endtask

  task automatic wait_rb(output int n);
    n = 0;
    while (!rb && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_page(input logic [7:0] row, input logic [7:0] col, input string req);
    int n;
    logic [7:0] d;
    logic e;
    bus_wr(1, 0, 8'h00);
    bus_wr(0, 1, col);
    bus_wr(0, 1, row);
    wait_rb(n);
    chk(n == T_READ, "R3 read busy", n, T_READ);
    for (int i = 0; i < 16; i++) begin
      int idx;
      idx = row[3:0] * 16 + ((col[3:0] + i) % 16);
      rd_byte(d, e);
      chk(e && d == mdl[idx], req, d, mdl[idx]);
    end
  endtask

  task automatic prog(input logic [7:0] row, input logic [7:0] col,
                      input int cnt, input logic [7:0] seed);
    int n;
    bus_wr(1, 0, 8'h80);
    bus_wr(0, 1, col);
    bus_wr(0, 1, row);
    for (int i = 0; i < cnt; i++) begin
      logic [7:0] d;
      d = seed ^ 8'(i * 37);
      bus_wr(0, 0, d);
      mdl[row[3:0] * 16 + ((col[3:0] + i) % 16)] &= d;
    end
    bus_wr(1, 0, 8'h10);
    wait_rb(n);
    chk(n == T_PROG, "R4 program busy", n, T_PROG);
  endtask

  task automatic erase(input logic [1:0] blk);
    int n;
    bus_wr(1, 0, 8'h60);
    bus_wr(0, 1, {4'h0, blk, 2'b00});
    bus_wr(1, 0, 8'hD0);
    wait_rb(n);
    chk(n == T_ERASE, "R5 erase busy", n, T_ERASE);
    for (int i = 0; i < 64; i++) mdl[blk * 64 + i] = 8'hFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] d;
    logic e;
    for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(rb == 1'b1, "R1 rb", rb, 1);
    chk(oe == 1'b0, "R1 oe", oe, 0);
    bus_wr(1, 0, 8'h70);
    rd_byte(d, e);
    chk(e && d == 8'hC0, "R1 status", d, 8'hC0);
    read_page(8'h09, 8'h00, "R1 erased array");

    // R3 R4 vector walk
    for (int v = 0; v < 5; v++) begin
      prog(VEC[v][31:24], VEC[v][23:16], int'(VEC[v][15:8]), VEC[v][7:0]);
      read_page(VEC[v][31:24], VEC[v][23:16], "R3 R4 readback");
    end

    // R2 writes with CE high ignored
    ce_n = 1'b1;
    bus_wr(1, 0, 8'h60);
    bus_wr(0, 1, 8'h04);
    bus_wr(1, 0, 8'hD0);
    chk(rb == 1'b1, "R2 no busy when deselected", rb, 1);
    ce_n = 1'b0;
    read_page(8'h05, 8'h03, "R2 data kept");

    // R5 erase block 0, block 1 intact
    erase(2'd0);
    for (int p = 0; p < 4; p++) read_page(8'(p), 8'h00, "R5 erased page");
    read_page(8'h05, 8'h00, "R5 other block");

    // R6 status held through busy end, R11 read cmd ignored while busy
    bus_wr(1, 0, 8'h60);
    bus_wr(0, 1, 8'h08);
    bus_wr(1, 0, 8'hD0);
    bus_wr(1, 0, 8'h70);
    bus_wr(1, 0, 8'h00);
    @(negedge clk) re_n = 1'b0;
    n = 0;
    for (int k = 0; k < T_ERASE + 4; k++) begin
      @(negedge clk);
      if (io_out[6] != rb || !oe) n++;
    end
    chk(n == 0, "R6 bit6 tracks rb", n, 0);
    chk(oe && io_out == 8'hC0, "R11 status kept after busy cmd", io_out, 8'hC0);
    re_n = 1'b1;
    for (int i = 0; i < 64; i++) mdl[128 + i] = 8'hFF;

    // R7 write protect
    prog(8'h0C, 8'h00, 2, 8'h55);
    wp_n = 1'b0;
    bus_wr(1, 0, 8'h60);
    bus_wr(0, 1, 8'h0C);
    bus_wr(1, 0, 8'hD0);
    chk(rb == 1'b1, "R7 erase refused", rb, 1);
    bus_wr(1, 0, 8'h70);
    rd_byte(d, e);
    chk(d == 8'h41, "R7 fail status", d, 8'h41);
    bus_wr(1, 0, 8'h80);
    bus_wr(0, 1, 8'h00);
    bus_wr(0, 1, 8'h0C);
    bus_wr(0, 0, 8'h00);
    bus_wr(1, 0, 8'h10);
    chk(rb == 1'b1, "R7 program refused", rb, 1);
    wp_n = 1'b1;
    bus_wr(1, 0, 8'h60);
    bus_wr(1, 0, 8'h70);
    rd_byte(d, e);
    chk(d == 8'hC0, "R7 fail cleared", d, 8'hC0);
    read_page(8'h0C, 8'h00, "R7 array unchanged");

    // R8 CE aborts read busy
    bus_wr(1, 0, 8'h00);
    bus_wr(0, 1, 8'h00);
    bus_wr(0, 1, 8'h0C);
    chk(rb == 1'b0, "R8 read busy", rb, 0);
    ce_n = 1'b1;
    @(negedge clk);
    chk(rb == 1'b1, "R8 read aborted", rb, 1);
    re_n = 1'b0;
    @(negedge clk);
    chk(oe == 1'b0, "R9 oe off when deselected", oe, 0);
    re_n = 1'b1;
    ce_n = 1'b0;
    rd_byte(d, e);
    chk(e == 1'b0, "R8 idle after deselect", e, 0);

    // R8 CE ignored during erase
    bus_wr(1, 0, 8'h60);
    bus_wr(0, 1, 8'h0C);
    bus_wr(1, 0, 8'hD0);
    ce_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rb == 1'b0, "R8 erase keeps busy", rb, 0);
    ce_n = 1'b0;
    wait_rb(n);
    chk(n == T_ERASE - 3, "R8 erase full length", n, T_ERASE - 3);
    for (int i = 0; i < 64; i++) mdl[192 + i] = 8'hFF;
    read_page(8'h0C, 8'h00, "R8 erase completed");

    // R10 unknown code ignored
    bus_wr(1, 0, 8'h70);
    bus_wr(1, 0, 8'h5A);
    rd_byte(d, e);
    chk(e && d == 8'hC0, "R10 status kept", d, 8'hC0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule